// File: doc/BRIEF.md
# Double-Buffered Compare Timer Channel

This block is one 16-bit timing channel. An up-counter advances on a count enable chosen from three prescaler taps (every clock, every fourth, every sixteenth) or from rising edges of an external pin. Two compare registers each drive an equality comparator. When the counter equals a register on a count enable, the matching output pulses for one clock. The counter can return to zero on a match with the second register, which makes that register the period. Otherwise it runs freely and raises a one-clock overflow pulse each time it wraps.

New compare values can be staged in write buffers so that a period change takes effect only at a period boundary. With buffering enabled and the counter running, writes land in the buffers. Both buffers are copied into the compare registers on the count enable where the counter matches the second register. When buffering is off, or when the counter is stopped, writes go straight to the compare registers.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset all three pulse outputs are low, both compare registers and both buffers hold zero, and the counter holds zero.
- R2: Clock select value 0 gives a count enable on every clock, 1 on every fourth clock and 2 on every sixteenth clock. The prescaler restarts when the run input rises, so the first match with the second register arrives (value+1)*N clocks after run rises, where N is 1, 4 or 16.
- R3: Clock select value 3 advances the counter once per rising edge of the external pin, after a two-flop synchronizer. With the pin static the counter does not move and no match pulse occurs.
- R4: While run is 0 the counter is held at zero and no match or overflow pulse is produced, even when a compare register equals zero. After run rises again counting starts from zero.
- R5: With clear-on-match at 1, the counter returns to zero on the count enable where it equals the second compare register, giving a period of value+1 count enables.
- R6: With clear-on-match at 0, the counter runs freely and wraps from 0xFFFF to 0x0000.
- R7: An overflow pulse lasting one clock is produced when a count enable wraps the counter from 0xFFFF to zero. When the same count enable clears the counter through a match with the second register, no overflow pulse is produced.
- R8: Each match output is a one-clock registered pulse, high in the clock after the edge whose count enable found the counter equal to its register. The first register's match never changes the counter.
- R9: With buffering disabled, a compare write takes effect from the next clock edge while the counter runs.
- R10: With buffering enabled and the counter running, writes go only to the buffers. Both buffers are copied into the compare registers on the count enable that matches the second register, and the copy uses the buffer contents held before any write in that same clock.
- R11: While the counter is stopped, writes go straight to the compare registers and their buffers even with buffering enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run bit: 1 counts, 0 stops and clears |
| clrOnMatch | input | 1 | Clear counter on match with second compare register |
| dbufEn | input | 1 | Enable write buffering of compare values |
| clkSel | input | 2 | Count source: 0 div1, 1 div4, 2 div16, 3 external pin |
| extPin | input | 1 | External count input, asynchronous |
| wrA | input | 1 | Write strobe for first compare value |
| wrDataA | input | 16 | First compare value |
| wrB | input | 1 | Write strobe for second compare value |
| wrDataB | input | 16 | Second compare value |
| matchA | output | 1 | One-clock pulse on match with first register |
| matchB | output | 1 | One-clock pulse on match with second register |
| ovfIrq | output | 1 | One-clock pulse on counter wrap |

## Verification
The match on the second register and the counter wrap can fall on the same count enable when that register holds 0xFFFF. The bench sets that value and runs the counter twice over the full range, once with clear-on-match off and once with it on. The first run must show the match and overflow pulses in the same cycle, 65536 clocks after start. The second run must show the match with no overflow at all. The buffer copy and a buffered write can also meet in one clock; the bench stages values just after a period boundary and judges the following two periods by the clock distance to each match pulse.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'd0,
    SRC_DIV4  = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_EXT   = 2'd3
  } cntSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;    // counter stopped and forced to zero
    logic step;    // count enable while running
    logic clear;   // return to zero on period match
    logic xfer;    // copy buffers into compare registers
    logic direct;  // compare writes bypass the buffers
  } tmrStrobes_t;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_chan_pkg::*;
#(
  parameter int DIV_A_LOG   = 2,
  parameter int DIV_B_LOG   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic [1:0] clkSel,
  input  logic       extPin,
  output logic       tick
);

  logic [DIV_B_LOG-1:0] presc;
  logic [SYNC_STAGES:0] extSh;
  logic tapA, tapB, extEdge, srcTick;

  // Prescaler restarts from zero whenever the channel is stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       presc <= '0;
    else if (!runEn) presc <= '0;
    else             presc <= presc + 1'b1;
  end

  assign tapA = &presc[DIV_A_LOG-1:0];
  assign tapB = &presc;

  // Synchronizer plus one stage of history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSh <= '0;
    else       extSh <= {extSh[SYNC_STAGES-1:0], extPin};
  end

  assign extEdge = extSh[SYNC_STAGES-1] & ~extSh[SYNC_STAGES];

  always_comb begin
    unique case (cntSrc_e'(clkSel))
      SRC_DIV1:  srcTick = 1'b1;
      SRC_DIV4:  srcTick = tapA;
      SRC_DIV16: srcTick = tapB;
      SRC_EXT:   srcTick = extEdge;
      default:   srcTick = 1'b0;
    endcase
  end

  assign tick = runEn & srcTick;

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        clrOnMatch,
  input  logic        dbufEn,
  input  logic        tick,
  input  logic        eqA,
  input  logic        eqB,
  input  logic        atMax,
  output tmrStrobes_t st,
  output logic        matchA,
  output logic        matchB,
  output logic        ovfIrq
);

  logic wrapNow;

  always_comb begin
    st.hold   = ~runEn;
    st.step   = runEn & tick;
    st.clear  = st.step & eqB & clrOnMatch;
    st.xfer   = st.step & eqB & dbufEn;
    st.direct = ~runEn | ~dbufEn;
  end

  // A match clear wins over the natural wrap
  assign wrapNow = st.step & atMax & ~st.clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchA <= 1'b0;
      matchB <= 1'b0;
      ovfIrq <= 1'b0;
    end else begin
      matchA <= st.step & eqA;
      matchB <= st.step & eqB;
      ovfIrq <= wrapNow;
    end
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCMP  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tmrStrobes_t                 st,
  input  logic [NCMP-1:0]             wrEn,
  input  logic [NCMP-1:0][CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]            cnt,
  output logic [NCMP-1:0]             eq,
  output logic                        atMax
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (st.hold)  cnt <= '0;
    else if (st.clear) cnt <= '0;
    else if (st.step)  cnt <= cnt + 1'b1;
  end

  assign atMax = &cnt;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic [CNT_W-1:0] bufQ, regQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufQ <= '0;
        regQ <= '0;
      end else begin
        if (wrEn[i]) bufQ <= wrData[i];
        if (wrEn[i] && st.direct) regQ <= wrData[i];
        else if (st.xfer)         regQ <= bufQ;
      end
    end

    assign eq[i] = (cnt == regQ);
  end

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_A_LOG   = 2,
  parameter int DIV_B_LOG   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             clrOnMatch,
  input  logic             dbufEn,
  input  logic [1:0]       clkSel,
  input  logic             extPin,
  input  logic             wrA,
  input  logic [CNT_W-1:0] wrDataA,
  input  logic             wrB,
  input  logic [CNT_W-1:0] wrDataB,
  output logic             matchA,
  output logic             matchB,
  output logic             ovfIrq
);

  localparam int NCMP = 2;

  tmrStrobes_t            st;
  logic                   tick, atMax;
  logic [NCMP-1:0]        eq;
  logic [CNT_W-1:0]       cntVal;

  tmr_tick_gen #(
    .DIV_A_LOG  (DIV_A_LOG),
    .DIV_B_LOG  (DIV_B_LOG),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk(clk), .rstN(rstN), .runEn(runEn), .clkSel(clkSel),
    .extPin(extPin), .tick(tick)
  );

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .clrOnMatch(clrOnMatch),
    .dbufEn(dbufEn), .tick(tick), .eqA(eq[0]), .eqB(eq[1]),
    .atMax(atMax), .st(st), .matchA(matchA), .matchB(matchB),
    .ovfIrq(ovfIrq)
  );

  tmr_datapath #(.CNT_W(CNT_W), .NCMP(NCMP)) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .wrEn({wrB, wrA}), .wrData({wrDataB, wrDataA}),
    .cnt(cntVal), .eq(eq), .atMax(atMax)
  );

endmodule

// File: rtl/cmp_timer_chan_chk.sv
module cmp_timer_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             clrOnMatch,
  input logic             matchA,
  input logic             matchB,
  input logic             ovfIrq,
  input logic [CNT_W-1:0] cntVal
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R4: stopping holds zero and silences all pulses
  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (cntVal == '0) && !matchA && !matchB && !ovfIrq);

  // R7: overflow marks a wrap from all-ones to zero
  a_r7_ovf_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (armed && ovfIrq) |-> (cntVal == '0) && ($past(cntVal) == {CNT_W{1'b1}}));

  // R5: period match with clear enabled leaves the counter at zero
  a_r5_clear_on_b: assert property (@(posedge clk) disable iff (!rstN)
    (armed && matchB && $past(clrOnMatch)) |-> (cntVal == '0));

  // R2: while running the counter holds, steps by one or returns to zero
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(runEn)) |->
      (cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 1'b1) || (cntVal == '0));

  // R8: a match pulse always comes from a running count enable
  a_r8_match_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (matchA || matchB)) |-> $past(runEn));

endmodule

bind cmp_timer_chan cmp_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .clrOnMatch(clrOnMatch),
  .matchA(matchA), .matchB(matchB), .ovfIrq(ovfIrq), .cntVal(cntVal)
);

// File: tb/sim_cmp_timer_chan.sv
`timescale 1ns/1ps
module sim_cmp_timer_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0, clrOnMatch = 1'b0, dbufEn = 1'b0;
  logic [1:0]  clkSel = 2'd0;
  logic        extPin = 1'b0;
  logic        wrA = 1'b0, wrB = 1'b0;
  logic [15:0] wrDataA = '0, wrDataB = '0;
  logic        matchA, matchB, ovfIrq;

  int totalCnt = 0, failCnt = 0;
  bit done = 1'b0, extGenOn = 1'b0;

  always #10 clk = ~clk;

  cmp_timer_chan u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .clrOnMatch(clrOnMatch),
    .dbufEn(dbufEn), .clkSel(clkSel), .extPin(extPin),
    .wrA(wrA), .wrDataA(wrDataA), .wrB(wrB), .wrDataB(wrDataB),
    .matchA(matchA), .matchB(matchB), .ovfIrq(ovfIrq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  // Write both compare values in one clock; starts and ends at a negedge
  task automatic writeBoth(input logic [15:0] a, input logic [15:0] b);
    wrA = 1'b1; wrDataA = a; wrB = 1'b1; wrDataB = b;
    @(posedge clk); @(negedge clk);
    wrA = 1'b0; wrB = 1'b0;
  endtask

  task automatic stopRun();
    runEn = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  // Counts clocks until matchB is seen; records first matchA and overflow
  task automatic measure(input int limit, output int tA, output int tB,
                         output int tO, output int nA);
    tA = -1; tB = -1; tO = -1; nA = 0;
    for (int n = 1; n <= limit; n++) begin
      @(posedge clk); @(negedge clk);
      if (matchA) begin nA++; if (tA < 0) tA = n; end
      if (ovfIrq && tO < 0) tO = n;
      if (matchB) begin tB = n; break; end
    end
  endtask

  task automatic t_reset();
    int tA, tB, tO, nA;
    #15;
    check(!matchA && !matchB && !ovfIrq, "R1 outputs low in reset",
          {matchA, matchB, ovfIrq}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    clrOnMatch = 1'b0; clkSel = 2'd0; runEn = 1'b1;
    measure(5, tA, tB, tO, nA);
    checkEq("R1 second register zero after reset", tB, 1);
    checkEq("R1 first register zero after reset", tA, 1);
    stopRun();
  endtask

  task automatic t_stop();
    int tA, tB, tO, nA, seen;
    seen = 0;
    dbufEn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (matchA || matchB || ovfIrq) seen++;
    end
    checkEq("R4 no pulses while stopped", seen, 0);
    writeBoth(16'd2, 16'd7);
    clrOnMatch = 1'b1; runEn = 1'b1;
    measure(50, tA, tB, tO, nA);
    checkEq("R11 stopped write to second register", tB, 8);
    checkEq("R11 stopped write to first register", tA, 3);
    measure(50, tA, tB, tO, nA);
    checkEq("R11 buffers updated by stopped write", tB, 8);
    repeat (3) @(negedge clk);
    stopRun();
    runEn = 1'b1;
    measure(50, tA, tB, tO, nA);
    checkEq("R4 restart counts from zero", tB, 8);
    stopRun();
    dbufEn = 1'b0;
  endtask

  task automatic t_div();
    int tA, tB, tO, nA;
    writeBoth(16'd1, 16'd4);
    clrOnMatch = 1'b1;
    clkSel = 2'd1; runEn = 1'b1;
    measure(200, tA, tB, tO, nA);
    checkEq("R2 divide by 4 period", tB, 20);
    checkEq("R2 divide by 4 first match", tA, 8);
    stopRun();
    clkSel = 2'd2; runEn = 1'b1;
    measure(200, tA, tB, tO, nA);
    checkEq("R2 divide by 16 period", tB, 80);
    checkEq("R2 divide by 16 first match", tA, 32);
    stopRun();
    clkSel = 2'd0; runEn = 1'b1;
    measure(200, tA, tB, tO, nA);
    checkEq("R2 divide by 1 first period", tB, 5);
    measure(200, tA, tB, tO, nA);
    checkEq("R5 clear on match period", tB, 5);
    checkEq("R8 first register match does not clear", tA, 2);
    stopRun();
  endtask

  task automatic t_dbuf();
    int tA, tB, tO, nA;
    clkSel = 2'd0; clrOnMatch = 1'b1; dbufEn = 1'b0;
    writeBoth(16'd10, 16'd99);
    runEn = 1'b1;
    measure(200, tA, tB, tO, nA);
    dbufEn = 1'b1;
    writeBoth(16'd20, 16'd49);
    measure(200, tA, tB, tO, nA);
    checkEq("R10 buffered write leaves second register", tB, 99);
    checkEq("R10 buffered write leaves first register", tA, 10);
    measure(200, tA, tB, tO, nA);
    checkEq("R10 second register loaded at period match", tB, 50);
    checkEq("R10 first register loaded at period match", tA, 21);
    dbufEn = 1'b0;
    writeBoth(16'd30, 16'd59);
    measure(200, tA, tB, tO, nA);
    checkEq("R9 direct write to second register", tB, 59);
    checkEq("R9 direct write to first register", tA, 30);
    stopRun();
  endtask

  task automatic t_ext();
    int tA, tB, tO, nA, seen;
    seen = 0;
    writeBoth(16'd1, 16'd3);
    clkSel = 2'd3; clrOnMatch = 1'b1; runEn = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (matchB || matchA) seen++;
    end
    checkEq("R3 static pin does not count", seen, 0);
    extGenOn = 1'b1;
    fork
      begin
        while (extGenOn) begin
          repeat (5) @(negedge clk);
          extPin = ~extPin;
        end
      end
    join_none
    measure(300, tA, tB, tO, nA);
    measure(300, tA, tB, tO, nA);
    checkEq("R3 external edge period", tB, 40);
    extGenOn = 1'b0;
    repeat (12) @(negedge clk);
    stopRun();
  endtask

  task automatic t_free();
    int tA, tB, tO, nA;
    clkSel = 2'd0; clrOnMatch = 1'b0; dbufEn = 1'b0;
    writeBoth(16'd5, 16'hFFFF);
    runEn = 1'b1;
    measure(70000, tA, tB, tO, nA);
    checkEq("R7 overflow with match at all-ones", tO, 65536);
    checkEq("R7 match and overflow same cycle", tB, 65536);
    checkEq("R8 one first-register pulse per wrap", nA, 1);
    checkEq("R8 first-register match timing", tA, 6);
    measure(20, tA, tB, tO, nA);
    checkEq("R6 free run wraps to zero", tA, 6);
    checkEq("R7 overflow lasts one clock", tO, -1);
    stopRun();
    clrOnMatch = 1'b1;
    runEn = 1'b1;
    measure(70000, tA, tB, tO, nA);
    checkEq("R7 match at all-ones with clear", tB, 65536);
    checkEq("R7 clear suppresses overflow", tO, -1);
    measure(20, tA, tB, tO, nA);
    checkEq("R5 clear at all-ones restarts", tA, 6);
    stopRun();
  endtask

  initial begin
    t_reset();
    t_stop();
    t_div();
    t_dbuf();
    t_ext();
    t_free();
    done = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

endmodule